// File: doc/BRIEF.md
# Three-Channel Compare and Wrap Timer

This peripheral holds three independent 32-bit counters behind a small register bus. Each channel keeps a live count, a reload value and two compare values. A channel counts up or down, one step per bus clock or one step per rising edge of a shared external tick. It reloads itself when it wraps past the end of its range and raises events when its count equals either compare value.

Events collect in one shared sticky status register. One shared mask register and a per-channel interrupt enable decide which events reach that channel's interrupt line. Loading the count and reload registers with 0xFFFFFFFF − (P − 1) and counting up gives an overflow every P cycles. A channel with all of its events masked keeps running and can serve as a free-running time base that software reads.

The bus has a write strobe and a read strobe, both sampled on the clock edge, a byte address and 32-bit data. Read data is registered and appears after the edge that samples the read strobe.

Top module: `tri_tick_timer`

## Requirements
- R1: After reset every register reads zero and all interrupt outputs are low.
- R2: Channel n's registers are at byte address 0x10·n plus 0x0 (count), 0x4 (reload), 0x8 (compare A) and 0xC (compare B). Control is at 0x30, status at 0x34 and mask at 0x38. Only word-aligned addresses decode. A read strobe returns the addressed value on `bus_rdata` after that clock edge, and an unmapped address reads zero.
- R3: Control bit 3n enables channel n. Bit 3n+1 = 0 selects the bus clock, and bit 9+n = 1 selects up counting. An enabled up channel adds one per cycle. A disabled channel holds its count.
- R4: In up mode, a step taken at 0xFFFFFFFF loads the reload value and sets status bit 3n+2 (overflow). Reload 0xFFFFFFFF − (P − 1) overflows every P cycles.
- R5: With control bit 9+n = 0 the channel subtracts one per step. A step taken at zero loads the reload value and sets status bit 3n+2.
- R6: A step taken while the count equals compare A sets status bit 3n. A step taken while it equals compare B sets status bit 3n+1.
- R7: A write to the count register presets it at any time. If the channel steps in the same cycle, the written value wins.
- R8: With control bit 3n+1 = 1 the channel steps once per rising edge of `ext_tick`, after a two-flop synchronizer. A level held high gives a single step.
- R9: Status bits are sticky and the status register is written as a whole, so a written 0 clears a bit. An event in the same cycle as a status write still sets its bit.
- R10: `irq[n]` is high when control bit 3n+2 is set and channel n has a status bit whose mask bit is 0. A mask bit of 1 blocks only the interrupt: the status still records the event and the counter keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ext_tick | input | 1 | Asynchronous external count tick |
| irq | output | 3 | Per-channel interrupt request |

## Verification
A corrupted count shows up at the first read of that channel, and again at the next wrap as a wrong reload value or a wrong time to overflow. A miscompared or dropped event appears in the status read in the cycle after the step that should have raised it. Because status bits are sticky, the error stays visible until software clears the bit. A wrong mask or enable bit shows on `irq` in the very next cycle, so the bench samples the interrupt lines at exact cycle offsets from the register write that started the channel.

// File: rtl/ttmr_pkg.sv
package ttmr_pkg;
  localparam int TMR_W = 32;

  // register slot inside a channel window
  localparam int REG_COUNT  = 0;
  localparam int REG_LOAD   = 1;
  localparam int REG_CMPA   = 2;
  localparam int REG_CMPB   = 3;

  // event slot inside a channel triplet
  localparam int EV_CMPA = 0;
  localparam int EV_CMPB = 1;
  localparam int EV_WRAP = 2;

  // control slot inside a channel triplet
  localparam int CB_RUN = 0;
  localparam int CB_EXT = 1;
  localparam int CB_IE  = 2;

  // true when the next step would leave the counter's range
  function automatic logic ttmr_at_wrap(input logic [TMR_W-1:0] cnt, input logic up);
    return up ? (&cnt) : ~(|cnt);
  endfunction

  // plain step without wrap handling
  function automatic logic [TMR_W-1:0] ttmr_step(input logic [TMR_W-1:0] cnt, input logic up);
    return up ? cnt + 1'b1 : cnt - 1'b1;
  endfunction
endpackage

// File: rtl/ttmr_tick_sync.sv
module ttmr_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tick_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = sync_q[STAGES-1] & ~prev_q;

  // R8: a held level produces exactly one step request
  a_r8_single_edge_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/ttmr_channel.sv
module ttmr_channel
  import ttmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             use_ext,
  input  logic             ext_edge,
  input  logic             count_up,
  input  logic [3:0]       reg_wr,
  input  logic [TMR_W-1:0] wdata,
  output logic [TMR_W-1:0] count_o,
  output logic [TMR_W-1:0] load_o,
  output logic [TMR_W-1:0] cmpa_o,
  output logic [TMR_W-1:0] cmpb_o,
  output logic [2:0]       ev_o
);
  logic [TMR_W-1:0] count_q, load_q, cmpa_q, cmpb_q;
  logic             advance;
  logic             at_wrap;

  assign advance = run & (use_ext ? ext_edge : 1'b1);
  assign at_wrap = ttmr_at_wrap(count_q, count_up);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      load_q  <= '0;
      cmpa_q  <= '0;
      cmpb_q  <= '0;
    end else begin
      if (reg_wr[REG_COUNT])  count_q <= wdata;
      else if (advance)       count_q <= at_wrap ? load_q : ttmr_step(count_q, count_up);
      if (reg_wr[REG_LOAD])   load_q  <= wdata;
      if (reg_wr[REG_CMPA])   cmpa_q  <= wdata;
      if (reg_wr[REG_CMPB])   cmpb_q  <= wdata;
    end
  end

  assign ev_o[EV_CMPA] = advance & (count_q == cmpa_q);
  assign ev_o[EV_CMPB] = advance & (count_q == cmpb_q);
  assign ev_o[EV_WRAP] = advance & at_wrap;

  assign count_o = count_q;
  assign load_o  = load_q;
  assign cmpa_o  = cmpa_q;
  assign cmpb_o  = cmpb_q;

  // R7: a preset beats any step in the same cycle
  a_r7_preset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr[REG_COUNT] |=> count_q == $past(wdata));

  // R3: no step request and no preset leaves the count alone
  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !reg_wr[REG_COUNT]) |=> $stable(count_q));

  // R4: up wrap reloads
  a_r4_up_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && count_up && (&count_q) && !reg_wr[REG_COUNT]) |=> count_q == $past(load_q));

  // R5: down wrap reloads
  a_r5_down_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !count_up && (count_q == '0) && !reg_wr[REG_COUNT]) |=> count_q == $past(load_q));
endmodule

// File: rtl/ttmr_evt_stat.sv
module ttmr_evt_stat #(
  parameter int NUM_CH = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3*NUM_CH-1:0]   ev_i,
  input  logic                  stat_wr,
  input  logic                  mask_wr,
  input  logic [3*NUM_CH-1:0]   wdata,
  input  logic [NUM_CH-1:0]     irq_en,
  output logic [3*NUM_CH-1:0]   status_o,
  output logic [3*NUM_CH-1:0]   mask_o,
  output logic [NUM_CH-1:0]     irq_o
);
  localparam int EVB = 3*NUM_CH;

  logic [EVB-1:0]    status_q, mask_q;
  logic [NUM_CH-1:0] pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= (stat_wr ? wdata : status_q) | ev_i;
      if (mask_wr) mask_q <= wdata;
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_irq
    assign pend[n]  = |(status_q[3*n +: 3] & ~mask_q[3*n +: 3]);
    assign irq_o[n] = irq_en[n] & pend[n];

    // R10: a fully masked channel never requests
    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q[3*n +: 3]) |-> !irq_o[n]);
  end

  for (genvar i = 0; i < EVB; i++) begin : g_bit
    // R6: every event lands in status
    a_r6_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i[i] |=> status_q[i]);
    // R9: a set bit stays set until software writes it
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[i] && !stat_wr) |=> status_q[i]);
    // R9: writing zero clears when no event competes
    a_r9_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !wdata[i] && !ev_i[i]) |=> !status_q[i]);
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
endmodule

// File: rtl/tri_tick_timer.sv
module tri_tick_timer
  import ttmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [TMR_W-1:0]  bus_wdata,
  output logic [TMR_W-1:0]  bus_rdata,
  input  logic              ext_tick,
  output logic [NUM_CH-1:0] irq
);
  localparam int EVB    = 3*NUM_CH;
  localparam int CTRL_W = 4*NUM_CH;
  localparam int SEL_W  = AW-4;
  localparam logic [AW-1:0] CTRL_A = AW'(NUM_CH*16);
  localparam logic [AW-1:0] STAT_A = AW'(NUM_CH*16 + 4);
  localparam logic [AW-1:0] MASK_A = AW'(NUM_CH*16 + 8);

  logic [CTRL_W-1:0] ctrl_q;
  logic [EVB-1:0]    ev_all, status, mask;
  logic [NUM_CH-1:0] irq_en;
  logic              ext_edge;
  logic              aligned;
  logic [SEL_W-1:0]  win;
  logic [TMR_W-1:0]  rd_val;
  logic [TMR_W-1:0]  count_a [NUM_CH];
  logic [TMR_W-1:0]  load_a  [NUM_CH];
  logic [TMR_W-1:0]  cmpa_a  [NUM_CH];
  logic [TMR_W-1:0]  cmpb_a  [NUM_CH];

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign win     = bus_addr[AW-1:4];

  ttmr_tick_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (ext_tick),
    .edge_o (ext_edge)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic [3:0] wsel;
    logic [2:0] ev;
    for (genvar k = 0; k < 4; k++) begin : g_sel
      assign wsel[k] = bus_wr & aligned & (win == SEL_W'(n)) & (bus_addr[3:2] == 2'(k));
    end

    ttmr_channel u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl_q[3*n + CB_RUN]),
      .use_ext  (ctrl_q[3*n + CB_EXT]),
      .ext_edge (ext_edge),
      .count_up (ctrl_q[EVB + n]),
      .reg_wr   (wsel),
      .wdata    (bus_wdata),
      .count_o  (count_a[n]),
      .load_o   (load_a[n]),
      .cmpa_o   (cmpa_a[n]),
      .cmpb_o   (cmpb_a[n]),
      .ev_o     (ev)
    );

    assign ev_all[3*n +: 3] = ev;
    assign irq_en[n]        = ctrl_q[3*n + CB_IE];
  end

  ttmr_evt_stat #(.NUM_CH(NUM_CH)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_i     (ev_all),
    .stat_wr  (bus_wr && bus_addr == STAT_A),
    .mask_wr  (bus_wr && bus_addr == MASK_A),
    .wdata    (bus_wdata[EVB-1:0]),
    .irq_en   (irq_en),
    .status_o (status),
    .mask_o   (mask),
    .irq_o    (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                          ctrl_q <= '0;
    else if (bus_wr && bus_addr == CTRL_A) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  always_comb begin
    rd_val = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (aligned && win == SEL_W'(n)) begin
        case (bus_addr[3:2])
          2'd0:    rd_val = count_a[n];
          2'd1:    rd_val = load_a[n];
          2'd2:    rd_val = cmpa_a[n];
          default: rd_val = cmpb_a[n];
        endcase
      end
    end
    if (bus_addr == CTRL_A) rd_val = {{(TMR_W-CTRL_W){1'b0}}, ctrl_q};
    if (bus_addr == STAT_A) rd_val = {{(TMR_W-EVB){1'b0}}, status};
    if (bus_addr == MASK_A) rd_val = {{(TMR_W-EVB){1'b0}}, mask};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  // R2: read data only moves on a read strobe
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R1: reset leaves every interrupt line low
  a_r1_irq_after_reset: assert property (@(posedge clk)
    !rst_n |=> irq == '0);
endmodule

// File: tb/tri_tick_timer_bench.sv
module tri_tick_timer_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_tick = 1'b0;
  logic [2:0]  irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;

  typedef struct {
    logic [7:0]  a;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t exp_q[$];
  sb_item_t cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_tick_timer u_tri_tick_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ext_tick  (ext_tick),
    .irq       (irq)
  );

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: pops one expectation per completed read
  always @(negedge clk) begin
    if (rst_n && rd_seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard underflow actual=0x%08h expected=none", bus_rdata);
      end else begin
        cur = exp_q.pop_front();
        if (bus_rdata !== cur.exp) begin
          failures++;
          $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h",
                   cur.tag, cur.a, bus_rdata, cur.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back('{a, e, tag});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic [2:0] e, input string tag);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
    end
  endtask

  // expected reload for a P-cycle period, restated as a subtraction from 2^32
  function automatic logic [31:0] period_load(input int p);
    logic [32:0] full = 33'h1_0000_0000;
    return 32'(full - 33'(p));
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;

    // R1 reset state
    chk_irq(3'b000, "R1 irq after reset");
    rd(8'h00, 32'h0, "R1 count0");
    rd(8'h24, 32'h0, "R1 load2");
    rd(8'h30, 32'h0, "R1 ctrl");
    rd(8'h34, 32'h0, "R1 status");
    rd(8'h38, 32'h0, "R1 mask");

    // R2 register map
    for (int n = 0; n < 3; n++)
      for (int k = 0; k < 4; k++)
        wr(8'(16*n + 4*k), 32'hC0DE_0000 | 32'(16*n + 4*k));
    for (int n = 0; n < 3; n++)
      for (int k = 0; k < 4; k++)
        rd(8'(16*n + 4*k), 32'hC0DE_0000 | 32'(16*n + 4*k), "R2 channel map");
    wr(8'h38, 32'h0A5);
    rd(8'h38, 32'h0A5, "R2 mask map");
    wr(8'h38, 32'h0);
    rd(8'h3C, 32'h0, "R2 unmapped");
    rd(8'h01, 32'h0, "R2 misaligned");

    // R3 up counting; R6 compare at zero
    wr(8'h34, 0); wr(8'h08, 0); wr(8'h0C, 0); wr(8'h00, 0);
    wr(8'h30, 32'h201); idle(4); wr(8'h30, 0);
    rd(8'h00, 32'd5, "R3 five steps");
    rd(8'h34, 32'h003, "R6 compare at zero");
    rd(8'h10, 32'hC0DE_0010, "R3 idle channel holds");

    // R7 preset while running
    wr(8'h30, 32'h201);
    wr(8'h00, 32'd100);
    rd(8'h00, 32'd100, "R7 preset beats step");
    wr(8'h30, 0);
    rd(8'h00, 32'd102, "R7 runs on from preset");

    // R4 up wrap
    wr(8'h34, 0); wr(8'h04, 32'd5); wr(8'h00, 32'hFFFF_FFFE);
    wr(8'h30, 32'h201); idle(1); wr(8'h30, 0);
    rd(8'h00, 32'd5, "R4 wrap reload");
    rd(8'h34, 32'h004, "R4 overflow flag");

    // R4 periodic overflow, P = 4, on channel 1
    wr(8'h34, 0); wr(8'h38, 0);
    wr(8'h14, period_load(4)); wr(8'h10, period_load(4));
    wr(8'h30, 32'h428);
    idle(3); chk_irq(3'b000, "R4 before first period");
    idle(1); chk_irq(3'b010, "R4 first period");
    wr(8'h34, 0);
    idle(2); chk_irq(3'b000, "R4 cleared mid period");
    idle(1); chk_irq(3'b010, "R4 second period");
    wr(8'h30, 0);

    // R10 mask and enable gating
    wr(8'h30, 32'h020); chk_irq(3'b010, "R10 ie only");
    wr(8'h38, 32'h020); chk_irq(3'b000, "R10 masked");
    wr(8'h38, 32'h0);   chk_irq(3'b010, "R10 unmasked");
    wr(8'h30, 32'h0);   chk_irq(3'b000, "R10 ie off");
    rd(8'h34, 32'h020, "R10 status kept");

    // R5 down counting on channel 2
    wr(8'h34, 0); wr(8'h28, 3); wr(8'h2C, 3); wr(8'h24, 7); wr(8'h20, 1);
    wr(8'h30, 32'h040); idle(1); wr(8'h30, 0);
    rd(8'h20, 32'd7, "R5 down wrap reload");
    rd(8'h34, 32'h100, "R5 overflow flag");
    wr(8'h30, 32'h040); wr(8'h30, 0);
    rd(8'h20, 32'd6, "R5 decrement");

    // R6 compare A and B on channel 0
    wr(8'h34, 0); wr(8'h08, 10); wr(8'h0C, 12); wr(8'h00, 8);
    wr(8'h30, 32'h201); idle(1); wr(8'h30, 0);
    rd(8'h34, 32'h000, "R6 no hit yet");
    wr(8'h30, 32'h201); wr(8'h30, 0);
    rd(8'h34, 32'h001, "R6 compare A");
    wr(8'h30, 32'h201); idle(1); wr(8'h30, 0);
    rd(8'h34, 32'h003, "R6 compare B");
    rd(8'h00, 32'd13, "R6 count after");

    // R9 status write and event race
    wr(8'h34, 32'h1FF); rd(8'h34, 32'h1FF, "R9 write ones");
    wr(8'h34, 32'h0AA); rd(8'h34, 32'h0AA, "R9 write pattern");
    wr(8'h34, 0);
    wr(8'h08, 20); wr(8'h00, 19);
    wr(8'h30, 32'h201); idle(1); wr(8'h34, 0); wr(8'h30, 0);
    rd(8'h34, 32'h001, "R9 event beats clear");
    idle(5);
    rd(8'h34, 32'h001, "R9 sticky");

    // R8 external tick on channel 2
    wr(8'h34, 0); wr(8'h20, 0);
    wr(8'h30, 32'h8C0); idle(5);
    rd(8'h20, 32'd0, "R8 no tick no step");
    for (int p = 0; p < 5; p++) begin
      ext_tick = 1'b1; idle(4);
      ext_tick = 1'b0; idle(4);
    end
    ext_tick = 1'b1; idle(12);
    ext_tick = 1'b0; idle(6);
    rd(8'h20, 32'd6, "R8 one step per edge");
    wr(8'h30, 0);
    rd(8'h34, 32'h0C0, "R8 compares on ticks");

    // R10 masked channel keeps counting
    wr(8'h34, 0); wr(8'h38, 32'h1FF); wr(8'h00, 0);
    wr(8'h30, 32'h205); idle(2);
    chk_irq(3'b000, "R10 all masked");
    wr(8'h30, 0);
    rd(8'h00, 32'd3, "R10 counts while masked");
    wr(8'h38, 0);

    idle(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule